// File: doc/BRIEF.md
# Virtually Tagged Instruction Fetch Cache

This block sits between a processor's instruction-fetch port and a slow lower-level memory. The fetch side presents a virtual address and holds it until the cache answers with the 32-bit instruction word at that address. Both the set index and the stored tag come straight from the virtual address, so a hit is decided without any address translation. A lookup that hits answers in the same cycle. A lookup that misses starts a refill: the cache asks the lower level for the whole 32-byte line that holds the address and takes it back as a burst of eight words. It then answers the waiting fetch.

The default build keeps 32 sets of two ways, which is 2 KB of instruction storage. In that build one replacement bit per set chooses the victim. A parameter instead selects a direct-mapped build, which compares a single line per lookup. Because the tags are virtual, every line has to be dropped whenever the address mapping changes. A single invalidate-all input does this in one cycle, and no software cache instruction is needed. An invalidate that arrives during a refill also throws away that refill's line.

Top module: `vt_icache`

## Requirements
- R1: After reset no line is valid. The first fetch gets no answer until a refill has been requested from the lower level and completed.
- R2: A refill is one request whose address is the fetch address with its low five bits cleared. The request and its address stay unchanged until `memReqReady`. Exactly eight data beats follow, and beat k holds the word at byte offset 4*k of the line.
- R3: A fetch to a resident line raises `fetchReady` in the same cycle it is presented, with the correct word and no request to the lower level.
- R4: While a refill is outstanding, `fetchReady` stays low. With a lower level that grants at once and returns one beat per cycle, the requested word (at any offset in the line) arrives exactly 10 cycles after a missing fetch is presented.
- R5: In the two-way build (`WAYS`=2), two lines with the same index bits [9:5] and different upper bits are resident together. A third such line evicts the one used least recently.
- R6: In the direct-mapped build (`WAYS`=1), a second line with the same index bits [9:5] evicts the first.
- R7: A one-cycle pulse on `flushAll` invalidates every line. Every fetch after it misses and refills from the lower level.
- R8: If `flushAll` is pulsed while a refill is outstanding, that refill does not make its line valid. The waiting fetch then starts a second refill, and the answer comes from the second one.
- R9: `fetchReady` is low in any cycle in which `flushAll` is high, and in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Invalidate every line (asserted on any mapping change) |
| fetchValid | input | 1 | Fetch request present, held until `fetchReady` |
| fetchAddr | input | ADDR_W | Virtual byte address of the instruction |
| fetchReady | output | 1 | `fetchData` is valid and the fetch is accepted this cycle |
| fetchData | output | 32 | Instruction word returned |
| memReqValid | output | 1 | Line refill request to the lower level |
| memReqReady | input | 1 | Lower level accepts the refill request |
| memReqAddr | output | ADDR_W | Line-aligned address of the refill |
| memBeatValid | input | 1 | One refill data word is present |
| memBeatData | input | 32 | Refill data word, in ascending offset order |

## Verification
A wrong valid bit shows up at the ports in one of two ways. A stuck-valid line answers a fetch in the cycle it is presented, when a refill request should have appeared. A lost line shows a refill request where the bench expected none. Both are visible at the first fetch to that set. To make a stale line visible, the bench changes its memory contents after each flush, so a line kept across a flush returns data that does not match. A wrong beat counter or a wrong way choice shows up as a wrong word returned, or as an extra refill, on the next fetch of that line. Counting refill requests and cycles to answer exposes replacement and discard errors within one or two fetches.

// File: rtl/vt_icache_pkg.sv
package vt_icache_pkg;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_BURST
  } fillState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFill;   // latch miss address, pick and invalidate victim
    logic writeBeat;   // store one refill word
    logic commitLine;  // mark refilled line valid
    logic touchHit;    // update replacement state on a hit
  } ctrlStrobe_t;

endpackage

// File: rtl/vt_icache_dp.sv
module vt_icache_dp
  import vt_icache_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              flushAll,
  input  ctrlStrobe_t       strb,
  input  logic [31:0]       beatData,
  output logic              hit,
  output logic [31:0]       hitData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              lastBeat
);

  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BEAT_W = $clog2(WORDS);

  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [31:0]      dataQ  [WAYS][SETS][WORDS];

  logic [IDX_W-1:0]  curIdx;
  logic [TAG_W-1:0]  curTag;
  logic [BEAT_W-1:0] curWord;
  logic [1:0]        unusedLow;

  assign curIdx    = fetchAddr[OFF_W+IDX_W-1:OFF_W];
  assign curTag    = fetchAddr[ADDR_W-1:OFF_W+IDX_W];
  assign curWord   = fetchAddr[OFF_W-1:2];
  assign unusedLow = fetchAddr[1:0];

  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] victimOH;

  always_comb begin
    hitData = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validQ[curIdx][w] && (tagQ[curIdx][w] == curTag);
      if (hitVec[w]) hitData = hitData | dataQ[w][curIdx][curWord];
    end
    hit = |hitVec;
  end

  // refill bookkeeping
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;
  logic [WAYS-1:0]   fillWayOH;
  logic [BEAT_W-1:0] beatCnt;

  assign memReqAddr = {fillTag, fillIdx, {OFF_W{1'b0}}};
  assign lastBeat   = (beatCnt == BEAT_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillIdx   <= '0;
      fillTag   <= '0;
      fillWayOH <= '0;
      beatCnt   <= '0;
    end else if (strb.startFill) begin
      fillIdx   <= curIdx;
      fillTag   <= curTag;
      fillWayOH <= victimOH;
      beatCnt   <= '0;
    end else if (strb.writeBeat) begin
      beatCnt   <= beatCnt + 1'b1;
    end
  end

  // replacement choice: direct-mapped or LRU bit per set
  generate
    if (WAYS == 1) begin : g_direct
      assign victimOH = 1'b1;
    end else begin : g_lru
      logic lruQ [SETS];  // way to evict next
      always_comb begin
        if (!validQ[curIdx][0])      victimOH = 2'b01;
        else if (!validQ[curIdx][1]) victimOH = 2'b10;
        else if (lruQ[curIdx])       victimOH = 2'b10;
        else                         victimOH = 2'b01;
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int s = 0; s < SETS; s++) lruQ[s] <= 1'b0;
        end else if (strb.commitLine) begin
          lruQ[fillIdx] <= fillWayOH[0];
        end else if (strb.touchHit) begin
          lruQ[curIdx] <= hitVec[0];
        end
      end
    end
  endgenerate

  // valid bits: flush wins over everything
  always_ff @(posedge clk) begin
    if (!rstN || flushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strb.startFill) begin
      validQ[curIdx] <= validQ[curIdx] & ~victimOH;
    end else if (strb.commitLine) begin
      validQ[fillIdx] <= validQ[fillIdx] | fillWayOH;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commitLine) begin
      for (int w = 0; w < WAYS; w++)
        if (fillWayOH[w]) tagQ[fillIdx][w] <= fillTag;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeBeat) begin
      for (int w = 0; w < WAYS; w++)
        if (fillWayOH[w]) dataQ[w][fillIdx][beatCnt] <= beatData;
    end
  end

endmodule

// File: rtl/vt_icache_ctrl.sv
module vt_icache_ctrl
  import vt_icache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flushAll,
  input  logic        fetchValid,
  input  logic        hit,
  input  logic        lastBeat,
  input  logic        memReqReady,
  input  logic        memBeatValid,
  output ctrlStrobe_t strb,
  output logic        fetchReady,
  output logic        memReqValid
);

  fillState_t stateQ, stateD;
  logic       discardQ;

  always_comb begin
    stateD      = stateQ;
    strb        = '0;
    fetchReady  = 1'b0;
    memReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (fetchValid && !flushAll) begin
          if (hit) begin
            fetchReady    = 1'b1;
            strb.touchHit = 1'b1;
          end else begin
            strb.startFill = 1'b1;
            stateD         = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_BURST;
      end
      ST_BURST: begin
        strb.writeBeat = memBeatValid;
        if (memBeatValid && lastBeat) begin
          strb.commitLine = !discardQ && !flushAll;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      discardQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.startFill)                    discardQ <= 1'b0;
      else if (flushAll && stateQ != ST_IDLE) discardQ <= 1'b1;
    end
  end

endmodule

// File: rtl/vt_icache.sv
module vt_icache
  import vt_icache_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [31:0]       fetchData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memBeatValid,
  input  logic [31:0]       memBeatData
);

  ctrlStrobe_t strb;
  logic        hit;
  logic        lastBeat;

  vt_icache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flushAll    (flushAll),
    .fetchValid  (fetchValid),
    .hit         (hit),
    .lastBeat    (lastBeat),
    .memReqReady (memReqReady),
    .memBeatValid(memBeatValid),
    .strb        (strb),
    .fetchReady  (fetchReady),
    .memReqValid (memReqValid)
  );

  vt_icache_dp #(
    .WAYS      (WAYS),
    .SETS      (SETS),
    .LINE_BYTES(LINE_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchAddr (fetchAddr),
    .flushAll  (flushAll),
    .strb      (strb),
    .beatData  (memBeatData),
    .hit       (hit),
    .hitData   (fetchData),
    .memReqAddr(memReqAddr),
    .lastBeat  (lastBeat)
  );

endmodule

// File: rtl/vt_icache_chk.sv
module vt_icache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushAll,
  input logic              fetchReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr
);

  // refill request is line aligned
  assert_req_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[4:0] == 5'd0));

  // request held stable until accepted
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // a hit answer never coexists with a refill request
  assert_hit_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady |-> !memReqValid);

  // no answer while a refill request is outstanding
  assert_stall_in_refill_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !fetchReady);

  // nothing survives a flush
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !fetchReady);

  // no answer during a flush
  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !fetchReady);

endmodule

bind vt_icache vt_icache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flushAll   (flushAll),
  .fetchReady (fetchReady),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr)
);

// File: tb/vt_icache_tb.sv
module vt_icache_tb_mem (
  input  logic        clk,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [7:0]  gen,
  output logic        reqReady,
  output logic        beatValid,
  output logic [31:0] beatData,
  output int          reqCount,
  output logic [31:0] lastAddr
);
  function automatic logic [31:0] word(input logic [31:0] a, input logic [7:0] g);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000 ^ {4{g}};
  endfunction

  initial begin
    reqReady = 0; beatValid = 0; beatData = 0; reqCount = 0; lastAddr = 0;
    forever begin
      @(negedge clk);
      if (reqValid) begin
        reqReady = 1;
        lastAddr = reqAddr;
        reqCount++;
        @(negedge clk);
        reqReady = 0;
        for (int i = 0; i < 8; i++) begin
          beatValid = 1;
          beatData  = word(lastAddr + 32'(4 * i), gen);
          @(negedge clk);
        end
        beatValid = 0;
      end
    end
  end
endmodule

module vt_icache_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  logic rstN = 0;

  logic        flA = 0, fvA = 0, flB = 0, fvB = 0;
  logic [31:0] faA = 0, faB = 0;
  logic        rdyA, rdyB, rqA, rqB, rrA, rrB, bvA, bvB;
  logic [31:0] dA, dB, raA, raB, bdA, bdB, lastA, lastB;
  logic [7:0]  genA = 8'h00, genB = 8'h00;
  int          cntA, cntB;

  vt_icache u_dut (
    .clk(clk), .rstN(rstN), .flushAll(flA), .fetchValid(fvA), .fetchAddr(faA),
    .fetchReady(rdyA), .fetchData(dA), .memReqValid(rqA), .memReqReady(rrA),
    .memReqAddr(raA), .memBeatValid(bvA), .memBeatData(bdA));

  vt_icache #(.WAYS(1)) u_dm (
    .clk(clk), .rstN(rstN), .flushAll(flB), .fetchValid(fvB), .fetchAddr(faB),
    .fetchReady(rdyB), .fetchData(dB), .memReqValid(rqB), .memReqReady(rrB),
    .memReqAddr(raB), .memBeatValid(bvB), .memBeatData(bdB));

  vt_icache_tb_mem u_memA (.clk(clk), .reqValid(rqA), .reqAddr(raA), .gen(genA),
    .reqReady(rrA), .beatValid(bvA), .beatData(bdA), .reqCount(cntA), .lastAddr(lastA));
  vt_icache_tb_mem u_memB (.clk(clk), .reqValid(rqB), .reqAddr(raB), .gen(genB),
    .reqReady(rrB), .beatValid(bvB), .beatData(bdB), .reqCount(cntB), .lastAddr(lastB));

  int total = 0, bad = 0;

  function automatic logic [31:0] expWord(input logic [31:0] a, input logic [7:0] g);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000 ^ {4{g}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fetchOn(input bit sel, input logic [31:0] addr,
                         output logic [31:0] data, output int cyc);
    @(negedge clk);
    if (sel) begin fvB = 1; faB = addr; end else begin fvA = 1; faA = addr; end
    cyc = 0;
    #1;
    while (!(sel ? rdyB : rdyA)) begin
      @(negedge clk); #1; cyc++;
    end
    data = sel ? dB : dA;
    @(negedge clk);
    if (sel) fvB = 0; else fvA = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R4 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic testReset();
    @(negedge clk); #1;
    check("R1 ready after reset", 32'(rdyA), 0);
    check("R1 no request after reset", 32'(rqA), 0);
  endtask

  task automatic testMissThenHit();
    logic [31:0] d; int c;
    fetchOn(0, 32'h0000_1014, d, c);
    check("R4 miss latency", c, 10);
    check("R2 word at offset 0x14", d, expWord(32'h1014, genA));
    check("R1 one refill", cntA, 1);
    check("R2 aligned request", lastA, 32'h0000_1000);
    fetchOn(0, 32'h0000_1000, d, c);
    check("R3 hit latency", c, 0);
    check("R3 hit data", d, expWord(32'h1000, genA));
    fetchOn(0, 32'h0000_101C, d, c);
    check("R3 last word hit", d, expWord(32'h101C, genA));
    check("R3 no new refill", cntA, 1);
  endtask

  task automatic testTwoWay();
    logic [31:0] d; int c; int base;
    base = cntA;
    fetchOn(0, 32'h0000_0040, d, c);
    fetchOn(0, 32'h1000_0040, d, c);
    check("R5 two fills", cntA - base, 2);
    fetchOn(0, 32'h0000_0044, d, c);
    check("R5 first still resident", c, 0);
    fetchOn(0, 32'h1000_0048, d, c);
    check("R5 second resident", c, 0);
    check("R5 second data", d, expWord(32'h1000_0048, genA));
    fetchOn(0, 32'h2000_0040, d, c);
    check("R5 third fills", cntA - base, 3);
    fetchOn(0, 32'h1000_0040, d, c);
    check("R5 recent line kept", c, 0);
    fetchOn(0, 32'h0000_0040, d, c);
    check("R5 LRU line evicted", cntA - base, 4);
  endtask

  task automatic testDirect();
    logic [31:0] d; int c;
    fetchOn(1, 32'h0000_0040, d, c);
    fetchOn(1, 32'h0000_0058, d, c);
    check("R6 hit after fill", c, 0);
    fetchOn(1, 32'h1000_0040, d, c);
    check("R6 conflict data", d, expWord(32'h1000_0040, genB));
    fetchOn(1, 32'h0000_0040, d, c);
    check("R6 first evicted", cntB, 3);
    check("R6 refetch latency", c, 10);
  endtask

  task automatic testFlush();
    logic [31:0] d; int c; int base;
    fetchOn(0, 32'h0000_0300, d, c);
    base = cntA;
    @(negedge clk); flA = 1;
    @(negedge clk); flA = 0;
    genA = 8'h5A;
    fetchOn(0, 32'h0000_0304, d, c);
    check("R7 refill after flush", cntA - base, 1);
    check("R7 new contents", d, expWord(32'h0304, genA));
    fetchOn(0, 32'h1000_0040, d, c);
    check("R7 other line gone", cntA - base, 2);
  endtask

  task automatic testFlushInRefill();
    logic [31:0] d; int c; int base;
    base = cntA;
    fork
      fetchOn(0, 32'h0000_0808, d, c);
      begin
        repeat (4) @(negedge clk);
        flA = 1;
        @(negedge clk);
        flA = 0;
      end
    join
    check("R8 two refills", cntA - base, 2);
    check("R8 latency of refetch", c, 20);
    check("R8 data", d, expWord(32'h0808, genA));
    fetchOn(0, 32'h0000_0800, d, c);
    check("R8 line now resident", c, 0);
  endtask

  task automatic testFlushBlocks();
    logic [31:0] d; int c;
    fetchOn(0, 32'h0000_0900, d, c);
    @(negedge clk);
    flA = 1; fvA = 1; faA = 32'h0000_0900;
    #1;
    check("R9 no answer during flush", 32'(rdyA), 0);
    @(negedge clk);
    flA = 0;
    #1;
    check("R9 no answer after flush", 32'(rdyA), 0);
    while (!rdyA) begin @(negedge clk); #1; end
    check("R9 data after refetch", dA, expWord(32'h0900, genA));
    @(negedge clk);
    fvA = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMissThenHit();
    testTwoWay();
    testDirect();
    testFlush();
    testFlushInRefill();
    testFlushBlocks();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule